// File: doc/BRIEF.md
# I2C Interrupt Status and Vector Unit

This unit gathers the event flags of an I2C controller into one place and exposes them to software through three 16-bit registers. The registers are an enable mask, a status word, and an interrupt vector. The bus engine sends a single-cycle pulse for each of seven events: arbitration lost, no-acknowledge, access ready, receive data ready, transmit data ready, stop detected, and addressed as slave. Each pulse sets a sticky flag. The bus engine also supplies two levels, bus busy and receive shift register full. These levels appear in the status word but are not stored.

Software normally waits for the interrupt line, then reads the vector register. That read returns a small code for the most urgent pending event that is enabled. For most events, the read also retires the flag. The receive-ready and transmit-ready flags are the exception: they stay set until the data path reports that the matching data register was accessed, or until software clears them in the status word.

Top module: `i2c_irq_vector`

## Requirements
- R1: After reset, every flag and every mask bit is zero. The vector register reads 0 and `irq` is low.
- R2: A pulse on an event input sets its flag on the next clock edge. The flags read back in the status word at these positions: arbitration lost bit 0, no-acknowledge bit 1, access ready bit 2, receive ready bit 3, transmit ready bit 4, stop detected bit 5, addressed as slave bit 6.
- R3: The mask register (offset 0x04) stores bits 6:0 exactly as written, using the same bit positions as the status flags. Bits 15:7 read 0.
- R4: `irq` is high exactly when at least one flag is set and its mask bit is one.
- R5: The vector register (offset 0x28) returns the code of the enabled pending flag with the smallest code, or 0 if there is none. The codes are: arbitration lost 1, no-acknowledge 2, access ready 3, receive ready 4, transmit ready 5, stop detected 6, addressed as slave 7.
- R6: A read of the vector register clears the flag it reports, except when the code is 4 or 5. Those flags remain set.
- R7: A write to the status register (offset 0x08) clears each flag in bits 6:0 that is written with a one. Flags written with a zero are unchanged.
- R8: A pulse on `rxDataRead` clears the receive-ready flag. A pulse on `txDataWrite` clears the transmit-ready flag.
- R9: Status bit 11 follows `rxShiftFull` and bit 12 follows `busBusy`. Writes to these bits have no effect.
- R10: An event pulse that arrives in the same cycle as a clear of its flag leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evArbLost | input | 1 | Arbitration-lost event pulse |
| evNoAck | input | 1 | No-acknowledge event pulse |
| evAccessRdy | input | 1 | Access-ready event pulse |
| evRxRdy | input | 1 | Receive-data-ready event pulse |
| evTxRdy | input | 1 | Transmit-data-ready event pulse |
| evStopDet | input | 1 | Stop-condition-detected event pulse |
| evAddrSlave | input | 1 | Addressed-as-slave event pulse |
| busBusy | input | 1 | Bus-busy level |
| rxShiftFull | input | 1 | Receive shift register full level |
| rxDataRead | input | 1 | Receive data register was read (pulse) |
| txDataWrite | input | 1 | Transmit data register was written (pulse) |
| regAddr | input | 6 | Register byte offset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data (combinational on `regAddr`) |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume three things about the inputs:
- `regWr` and `regRd` are never high in the same cycle.
- Event and data-access inputs are single-cycle pulses that are synchronous to `clk`.
- Each read of the vector register lasts exactly one cycle, so each read retires at most one flag.

The bench drives every input at the falling edge. It holds each strobe for exactly one cycle and never raises a read and a write together. It samples read data before the rising edge that applies a vector-read clear.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int REG_W   = 16;
  localparam int ADDR_W  = 6;
  localparam int NUM_EVT = 7;

  localparam logic [ADDR_W-1:0] OFS_MASK   = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_VECTOR = 6'h28;

  localparam int RX_IDX       = 3;
  localparam int TX_IDX       = 4;
  localparam int BIT_RS_FULL  = 11;
  localparam int BIT_BUS_BUSY = 12;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_VECTOR = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrMask;
    logic   clrStatus;
    logic   rdVector;
    rdSel_e rdSel;
  } regStrobe_t;
endpackage

// File: rtl/i2c_irq_ctrl.sv
module i2c_irq_ctrl
  import i2c_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  output regStrobe_t        strobe
);
  always_comb begin
    strobe = '{wrMask: 1'b0, clrStatus: 1'b0, rdVector: 1'b0, rdSel: SEL_NONE};
    unique case (regAddr)
      OFS_MASK: begin
        strobe.rdSel  = SEL_MASK;
        strobe.wrMask = regWr;
      end
      OFS_STATUS: begin
        strobe.rdSel     = SEL_STATUS;
        strobe.clrStatus = regWr;
      end
      OFS_VECTOR: begin
        strobe.rdSel    = SEL_VECTOR;
        strobe.rdVector = regRd;
      end
      default: ;
    endcase
  end

  // A single register access raises at most one action strobe.
  assert_strobe_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.wrMask, strobe.clrStatus, strobe.rdVector}));
endmodule

// File: rtl/i2c_irq_datapath.sv
module i2c_irq_datapath
  import i2c_irq_pkg::*;
#(
  parameter int                N_EVT     = NUM_EVT,
  parameter int                W         = REG_W,
  parameter logic [N_EVT-1:0]  STICKY    = N_EVT'((1 << RX_IDX) | (1 << TX_IDX))
) (
  input  logic             clk,
  input  logic             rst_n,
  input  regStrobe_t       strobe,
  input  logic [N_EVT-1:0] evPulse,
  input  logic             busBusy,
  input  logic             rxShiftFull,
  input  logic             rxDataRead,
  input  logic             txDataWrite,
  input  logic [W-1:0]     wrData,
  output logic [W-1:0]     rdData,
  output logic             irq
);
  localparam int VEC_W = $clog2(N_EVT + 1);

  logic [N_EVT-1:0] flagsQ, maskQ, pend, vecHit, clrBits, accessClr;
  logic [VEC_W-1:0] vecCode;
  logic [W-1:0]     statusWord;

  assign pend = flagsQ & maskQ;

  always_comb begin
    vecCode = '0;
    for (int i = N_EVT - 1; i >= 0; i--)
      if (pend[i]) vecCode = VEC_W'(i + 1);
  end

  generate
    for (genvar g = 0; g < N_EVT; g++) begin : gHit
      assign vecHit[g] = (vecCode == VEC_W'(g + 1));
      assign accessClr[g] = (g == RX_IDX) ? rxDataRead :
                            (g == TX_IDX) ? txDataWrite : 1'b0;
    end
  endgenerate

  assign clrBits = (strobe.clrStatus ? wrData[N_EVT-1:0] : '0)
                 | (strobe.rdVector ? (vecHit & ~STICKY) : '0)
                 | accessClr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flagsQ <= '0;
      maskQ  <= '0;
    end else begin
      flagsQ <= (flagsQ & ~clrBits) | evPulse;
      if (strobe.wrMask) maskQ <= wrData[N_EVT-1:0];
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[N_EVT-1:0]  = flagsQ;
    statusWord[BIT_RS_FULL]  = rxShiftFull;
    statusWord[BIT_BUS_BUSY] = busBusy;
  end

  always_comb begin
    unique case (strobe.rdSel)
      SEL_MASK:   rdData = W'(maskQ);
      SEL_STATUS: rdData = statusWord;
      SEL_VECTOR: rdData = W'(vecCode);
      default:    rdData = '0;
    endcase
  end

  assign irq = |pend;

  // Interrupt line agrees with the priority encoder output.
  assert_irq_vs_vector_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (vecCode != '0));
  // A nonzero code always names an enabled pending flag.
  assert_vector_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vecCode != '0) |-> (flagsQ[vecCode - VEC_W'(1)] && maskQ[vecCode - VEC_W'(1)]));
  // Every event pulse is visible in the flags one cycle later.
  assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evPulse) |=> ((flagsQ & $past(evPulse)) == $past(evPulse)));
  // The mask only changes on a mask write.
  assert_mask_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.wrMask |=> $stable(maskQ));
  // A flag only drops after some clearing action.
  assert_flag_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(flagsQ) & ~flagsQ) != '0) |->
      $past(strobe.clrStatus || strobe.rdVector || rxDataRead || txDataWrite));
endmodule

// File: rtl/i2c_irq_vector.sv
module i2c_irq_vector
  import i2c_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evArbLost,
  input  logic              evNoAck,
  input  logic              evAccessRdy,
  input  logic              evRxRdy,
  input  logic              evTxRdy,
  input  logic              evStopDet,
  input  logic              evAddrSlave,
  input  logic              busBusy,
  input  logic              rxShiftFull,
  input  logic              rxDataRead,
  input  logic              txDataWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              irq
);
  regStrobe_t         strobe;
  logic [NUM_EVT-1:0] evPulse;

  assign evPulse = {evAddrSlave, evStopDet, evTxRdy, evRxRdy,
                    evAccessRdy, evNoAck, evArbLost};

  i2c_irq_ctrl i_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .regAddr (regAddr),
    .regWr   (regWr),
    .regRd   (regRd),
    .strobe  (strobe)
  );

  i2c_irq_datapath i_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .evPulse     (evPulse),
    .busBusy     (busBusy),
    .rxShiftFull (rxShiftFull),
    .rxDataRead  (rxDataRead),
    .txDataWrite (txDataWrite),
    .wrData      (regWrData),
    .rdData      (regRdData),
    .irq         (irq)
  );
endmodule

// File: tb/test_i2c_irq_vector.sv
module test_i2c_irq_vector;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [6:0]  ev = '0;
  logic        busBusy = 0, rxShiftFull = 0, rxDataRead = 0, txDataWrite = 0;
  logic [5:0]  regAddr = '0;
  logic        regWr = 0, regRd = 0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        irq;
  int          nRun = 0, nFail = 0;
  logic [15:0] rd;

  localparam logic [5:0] A_MASK = 6'h04, A_STAT = 6'h08, A_VEC = 6'h28;

  always #2.5 clk = ~clk;

  i2c_irq_vector i_i2c_irq_vector (
    .clk(clk), .rst_n(rst_n),
    .evArbLost(ev[0]), .evNoAck(ev[1]), .evAccessRdy(ev[2]), .evRxRdy(ev[3]),
    .evTxRdy(ev[4]), .evStopDet(ev[5]), .evAddrSlave(ev[6]),
    .busBusy(busBusy), .rxShiftFull(rxShiftFull),
    .rxDataRead(rxDataRead), .txDataWrite(txDataWrite),
    .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWrData(regWrData), .regRdData(regRdData), .irq(irq));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); regAddr = a; regWrData = d; regWr = 1;
    @(negedge clk); regWr = 0;
  endtask

  task automatic regRead(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk); regAddr = a; regRd = 1;
    #1 d = regRdData;
    @(negedge clk); regRd = 0;
  endtask

  task automatic pulse(input logic [6:0] e);
    @(negedge clk); ev = e;
    @(negedge clk); ev = '0;
  endtask

  function automatic logic [15:0] lowCode(input logic [6:0] p);
    for (int i = 0; i < 7; i++) if (p[i]) return 16'(i + 1);
    return 16'd0;
  endfunction

  initial begin
    #200000;
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [6:0] ms [6];
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    regRead(A_STAT, rd); check("R1 status", rd, 16'h0);
    regRead(A_MASK, rd); check("R1 mask", rd, 16'h0);
    regRead(A_VEC, rd);  check("R1 vector", rd, 16'h0);
    check("R1 irq", 16'(irq), 16'h0);

    // R2 / R7: every event position, set then write-one-clear
    for (int i = 0; i < 7; i++) begin
      pulse(7'(1 << i));
      regRead(A_STAT, rd); check("R2 flag position", rd, 16'(1 << i));
      regWrite(A_STAT, 16'(~(1 << i)) & 16'h007F);
      regRead(A_STAT, rd); check("R7 zero bits keep flag", rd, 16'(1 << i));
      regWrite(A_STAT, 16'(1 << i));
      regRead(A_STAT, rd); check("R7 one clears flag", rd, 16'h0);
    end

    // R3 mask read/write
    for (int m = 0; m < 128; m++) begin
      regWrite(A_MASK, 16'(m) | 16'hFF80);
      regRead(A_MASK, rd); check("R3 mask readback", rd, 16'(m));
    end

    // R4 / R5 sweep of flag patterns against several masks
    for (int f = 0; f < 128; f++) begin
      ms[0] = 7'h00; ms[1] = 7'h7F; ms[2] = 7'h55; ms[3] = 7'h2A;
      ms[4] = 7'(f); ms[5] = ~7'(f);
      for (int k = 0; k < 6; k++) begin
        regWrite(A_STAT, 16'h007F);
        regWrite(A_MASK, 16'(ms[k]));
        pulse(7'(f));
        #1 check("R4 irq", 16'(irq), 16'(|(7'(f) & ms[k])));
        regRead(A_VEC, rd); check("R5 vector code", rd, lowCode(7'(f) & ms[k]));
      end
    end

    // R6 / R8 drain sequence with all events pending
    regWrite(A_STAT, 16'h007F);
    regWrite(A_MASK, 16'h007F);
    pulse(7'h7F);
    regRead(A_VEC, rd); check("R6 first code", rd, 16'd1);
    regRead(A_VEC, rd); check("R6 second code", rd, 16'd2);
    regRead(A_VEC, rd); check("R6 third code", rd, 16'd3);
    regRead(A_VEC, rd); check("R6 rx code", rd, 16'd4);
    regRead(A_VEC, rd); check("R6 rx stays", rd, 16'd4);
    @(negedge clk); rxDataRead = 1; @(negedge clk); rxDataRead = 0;
    regRead(A_VEC, rd); check("R8 rx cleared by access", rd, 16'd5);
    regRead(A_VEC, rd); check("R6 tx stays", rd, 16'd5);
    @(negedge clk); txDataWrite = 1; @(negedge clk); txDataWrite = 0;
    regRead(A_VEC, rd); check("R8 tx cleared by access", rd, 16'd6);
    regRead(A_VEC, rd); check("R6 stop then slave", rd, 16'd7);
    regRead(A_VEC, rd); check("R6 drained", rd, 16'd0);
    check("R4 irq low after drain", 16'(irq), 16'h0);
    regRead(A_STAT, rd); check("R6 status empty", rd, 16'h0);

    // R9 level bits
    busBusy = 1; rxShiftFull = 1;
    regRead(A_STAT, rd); check("R9 levels high", rd, 16'h1800);
    regWrite(A_STAT, 16'hFFFF);
    regRead(A_STAT, rd); check("R9 write ignored", rd, 16'h1800);
    busBusy = 0;
    regRead(A_STAT, rd); check("R9 busy follows", rd, 16'h0800);
    rxShiftFull = 0;
    regRead(A_STAT, rd); check("R9 full follows", rd, 16'h0000);

    // R10 set wins over same-cycle clear
    @(negedge clk); regAddr = A_STAT; regWrData = 16'h0001; regWr = 1; ev = 7'h01;
    @(negedge clk); regWr = 0; ev = '0;
    regRead(A_STAT, rd); check("R10 set beats clear", rd, 16'h0001);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule